// File: doc/BRIEF.md
# I2C Master Interrupt Status and Enable Registers

This block holds the interrupt bookkeeping for an I2C master. Single-cycle event pulses arrive from the FIFO logic and from the transaction engine. Each pulse sets a sticky bit in an interrupt cause register. Software clears a cause by writing a one to its bit, so writing back a value just read clears exactly the causes that were seen. An enable register of the same layout selects which causes may raise the interrupt line. That line is a registered level, held by a two-state machine.

A second register reports the outcome of the last transfer. It has five bits: completed, arbitration abort, missing acknowledge, no device and timeout. The completed bit clears itself when software reads this register. All five bits can also be cleared by writing ones. The same register shows live slave-busy and master-busy indications.

Access is through a simple single-cycle port. A write takes effect at the clock edge. Read data is combinational in the cycle of the access. The side effect of a read takes effect at the edge that ends that cycle.

Top module: `i2c_irq_regs`

## Requirements
- R1: After reset the enable register (offset 0), the cause register (offset 1) and the result bits of the transfer register (offset 2) read zero, and `irq` is low.
- R2: A pulse on `fifo_evt[i]` sets cause bit i (0 TX almost-empty, 1 RX almost-full, 2 TX underrun, 3 TX overrun, 4 RX underrun, 5 RX overrun, 6 trailing). A pulse on `xfer_evt[j]` sets cause bit 7+j (j: 0 completed, 1 abort, 2 no-acknowledge, 3 no-device, 4 timeout). Each bit is readable from the cycle after the pulse edge and stays set once the pulse ends.
- R3: A write to offset 1 clears every cause bit written as one and leaves the bits written as zero unchanged. Writing back a value just read clears all bits that were read.
- R4: When a pulse and a clearing write for the same cause bit fall in the same cycle, the bit stays set.
- R5: Offset 0 is a read/write enable register with bits 11:0 in the same positions as the cause register. Bits 31:12 read zero.
- R6: `irq` is high exactly one cycle after some cause bit is set with its enable bit set. A pending cause whose enable bit is clear does not raise `irq`.
- R7: Writing zero to the enable register drops `irq` one cycle after the write edge, while the cause bits stay set.
- R8: Offset 2 bits 4:0 (0 completed, 1 abort, 2 no-acknowledge, 3 no-device, 4 timeout) are set by the matching `xfer_evt` pulse and are sticky.
- R9: A read of offset 2 clears bit 0 at the edge ending that read, and leaves bits 4:1 unchanged. A completed pulse in the same cycle as the read keeps bit 0 set.
- R10: A write to offset 2 clears each of bits 4:0 written as one.
- R11: Offset 2 bit 16 shows `busy_slave` and bit 17 shows `busy_master`, in the cycle of the read.
- R12: Reading the cause register does not clear it. Offsets other than 0, 1 and 2 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Register offset in words |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the access cycle |
| fifo_evt | input | FIFO_EVENTS (7) | FIFO event pulses |
| xfer_evt | input | XFER_EVENTS (5) | Transfer result pulses |
| busy_slave | input | 1 | Slave busy level |
| busy_master | input | 1 | Master busy level |
| irq | output | 1 | Registered interrupt level |

## Verification
Register state changes at the edge that closes a write, a pulse or a read. It is therefore due at the first falling-edge sample after that edge. The read data itself is due in the same cycle as the access, 1 ns after the inputs are applied. `irq` lags the cause and enable registers by one further edge. The tests check it low at the first sample and high at the second, so the one-cycle latency of R6 and R7 is pinned exactly. The clear-on-read of R9 is checked by a second read one cycle after the first. All stimulus is applied on falling edges, so every expected value sits at a fixed cycle offset.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int N_FIFO_EV    = 7;
    localparam int N_XFER_EV    = 5;
    localparam int SLV_BUSY_POS = 16;
    localparam int MST_BUSY_POS = 17;
    localparam int OFS_ENABLE   = 0;
    localparam int OFS_CAUSE    = 1;
    localparam int OFS_RESULT   = 2;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/i2c_irq_sticky.sv
module i2c_irq_sticky #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);
    // set has priority over clear in the same cycle
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[b] <= 1'b0;
            else if (set_i[b])
                q_o[b] <= 1'b1;
            else if (clr_i[b])
                q_o[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_irq_state.sv
module i2c_irq_state
    import i2c_irq_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cause_i,
    input  logic [WIDTH-1:0] enable_i,
    output logic             irq_o
);
    irq_state_e state_q, state_d;
    logic       any_pend;

    assign any_pend = |(cause_i & enable_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_pend)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_pend) state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/i2c_irq_regport.sv
module i2c_irq_regport
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int N_CAUSE = 12,
    parameter int N_XFER  = 5
) (
    input  logic               sel_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [N_CAUSE-1:0] en_q_i,
    input  logic [N_CAUSE-1:0] cause_q_i,
    input  logic [N_XFER-1:0]  result_q_i,
    input  logic               busy_slv_i,
    input  logic               busy_mst_i,
    output logic               en_we_o,
    output logic [N_CAUSE-1:0] cause_clr_o,
    output logic [N_XFER-1:0]  result_clr_o,
    output logic               result_rd_o,
    output logic [DATA_W-1:0]  rdata_o
);
    logic hit_en, hit_cause, hit_res, do_wr, do_rd;
    logic unused_wbits;

    assign unused_wbits = ^wdata_i[DATA_W-1:N_CAUSE];

    always_comb begin
        hit_en    = (addr_i == ADDR_W'(OFS_ENABLE));
        hit_cause = (addr_i == ADDR_W'(OFS_CAUSE));
        hit_res   = (addr_i == ADDR_W'(OFS_RESULT));
        do_wr     = sel_i &  wr_i;
        do_rd     = sel_i & ~wr_i;

        en_we_o      = do_wr & hit_en;
        cause_clr_o  = (do_wr & hit_cause) ? wdata_i[N_CAUSE-1:0] : '0;
        result_clr_o = (do_wr & hit_res)   ? wdata_i[N_XFER-1:0]  : '0;
        result_rd_o  = do_rd & hit_res;
        if (result_rd_o) result_clr_o[0] = 1'b1;

        rdata_o = '0;
        if (do_rd) begin
            if (hit_en) begin
                rdata_o[N_CAUSE-1:0] = en_q_i;
            end else if (hit_cause) begin
                rdata_o[N_CAUSE-1:0] = cause_q_i;
            end else if (hit_res) begin
                rdata_o[N_XFER-1:0]  = result_q_i;
                rdata_o[SLV_BUSY_POS] = busy_slv_i;
                rdata_o[MST_BUSY_POS] = busy_mst_i;
            end
        end
    end
endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int FIFO_EVENTS = N_FIFO_EV,
    parameter int XFER_EVENTS = N_XFER_EV
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [FIFO_EVENTS-1:0] fifo_evt,
    input  logic [XFER_EVENTS-1:0] xfer_evt,
    input  logic                   busy_slave,
    input  logic                   busy_master,
    output logic                   irq
);
    localparam int N_CAUSE = FIFO_EVENTS + XFER_EVENTS;

    logic [N_CAUSE-1:0]     set_vec;
    logic [N_CAUSE-1:0]     cause_q;
    logic [N_CAUSE-1:0]     cause_clr;
    logic [N_CAUSE-1:0]     en_q;
    logic [XFER_EVENTS-1:0] result_q;
    logic [XFER_EVENTS-1:0] result_clr;
    logic                   en_we;
    logic                   result_rd;

    assign set_vec = {xfer_evt, fifo_evt};

    i2c_irq_regport #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_CAUSE(N_CAUSE),
        .N_XFER (XFER_EVENTS)
    ) u_port (
        .sel_i       (bus_sel),
        .wr_i        (bus_wr),
        .addr_i      (bus_addr),
        .wdata_i     (bus_wdata),
        .en_q_i      (en_q),
        .cause_q_i   (cause_q),
        .result_q_i  (result_q),
        .busy_slv_i  (busy_slave),
        .busy_mst_i  (busy_master),
        .en_we_o     (en_we),
        .cause_clr_o (cause_clr),
        .result_clr_o(result_clr),
        .result_rd_o (result_rd),
        .rdata_o     (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= bus_wdata[N_CAUSE-1:0];
    end

    i2c_irq_sticky #(.WIDTH(N_CAUSE)) u_cause (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(set_vec),
        .clr_i(cause_clr),
        .q_o  (cause_q)
    );

    i2c_irq_sticky #(.WIDTH(XFER_EVENTS)) u_result (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(xfer_evt),
        .clr_i(result_clr),
        .q_o  (result_q)
    );

    i2c_irq_state #(.WIDTH(N_CAUSE)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause_q),
        .enable_i(en_q),
        .irq_o   (irq)
    );
endmodule

// File: rtl/i2c_irq_chk.sv
module i2c_irq_chk #(
    parameter int WIDTH = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] set_vec,
    input logic [WIDTH-1:0] cause_q,
    input logic [WIDTH-1:0] en_q,
    input logic             irq,
    input logic             result_rd,
    input logic             done_evt,
    input logic             done_q
);
    AST_CAUSE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((cause_q & $past(set_vec)) == $past(set_vec))); // R4

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(set_vec)) == '0)); // R2

    AST_IRQ_LAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(cause_q & en_q)))); // R6

    AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !irq); // R7

    AST_DONE_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (result_rd && !done_evt) |=> !done_q); // R9
endmodule

bind i2c_irq_regs i2c_irq_chk #(.WIDTH(N_CAUSE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .cause_q  (cause_q),
    .en_q     (en_q),
    .irq      (irq),
    .result_rd(result_rd),
    .done_evt (xfer_evt[0]),
    .done_q   (result_q[0])
);

// File: tb/sim_i2c_irq_regs.sv
module sim_i2c_irq_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  fifo_evt = '0;
    logic [4:0]  xfer_evt = '0;
    logic        busy_slave = 1'b0;
    logic        busy_master = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    localparam int EN = 0, ST = 1, XS = 2;

    always #10 clk = ~clk;

    i2c_irq_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_evt(fifo_evt), .xfer_evt(xfer_evt), .busy_slave(busy_slave),
        .busy_master(busy_master), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input int a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[3:0]; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic reg_rd(input int a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[3:0];
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] f, input logic [4:0] x);
        fifo_evt = f; xfer_evt = x;
        @(negedge clk);
        fifo_evt = '0; xfer_evt = '0;
    endtask

    task automatic clear_all();
        reg_wr(ST, 32'hFFF);
        reg_wr(XS, 32'h1F);
        reg_wr(EN, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 32'h0);
        reg_rd(EN, d); check("R1 enable", d, 32'h0);
        reg_rd(ST, d); check("R1 cause", d, 32'h0);
        reg_rd(XS, d); check("R1 result", d, 32'h0);
    endtask

    task automatic t_set_and_clear();
        logic [31:0] d;
        pulse(7'h24, 5'h00);
        reg_rd(ST, d); check("R2 fifo causes", d, 32'h024);
        pulse(7'h00, 5'h02);
        @(negedge clk);
        reg_rd(ST, d); check("R2 abort cause bit8, sticky", d, 32'h124);
        reg_rd(ST, d); check("R12 cause not read-cleared", d, 32'h124);
        reg_wr(ST, 32'h004);
        reg_rd(ST, d); check("R3 partial clear", d, 32'h120);
        reg_wr(ST, d);
        reg_rd(ST, d); check("R3 write-back clears", d, 32'h0);
        clear_all();
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        fifo_evt = 7'h08;
        reg_wr(ST, 32'h008);
        fifo_evt = '0;
        reg_rd(ST, d); check("R4 set wins over clear", d, 32'h008);
        clear_all();
    endtask

    task automatic t_enable_reg();
        logic [31:0] d;
        reg_wr(EN, 32'hFFFF_FFFF);
        reg_rd(EN, d); check("R5 enable width", d, 32'hFFF);
        reg_wr(EN, 32'h0A5);
        reg_rd(EN, d); check("R5 enable value", d, 32'h0A5);
        clear_all();
    endtask

    task automatic t_irq();
        logic [31:0] d;
        reg_wr(EN, 32'h001);
        pulse(7'h02, 5'h00);
        @(negedge clk); @(negedge clk);
        check("R6 disabled cause no irq", {31'b0, irq}, 32'h0);
        pulse(7'h01, 5'h00);
        check("R6 irq not before latency", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R6 irq one cycle after cause", {31'b0, irq}, 32'h1);
        reg_wr(EN, 32'h0);
        check("R7 irq holds one cycle", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R7 masked irq low", {31'b0, irq}, 32'h0);
        reg_rd(ST, d); check("R7 causes kept", d, 32'h003);
        clear_all();
    endtask

    task automatic t_result();
        logic [31:0] d;
        pulse(7'h00, 5'h01);
        reg_rd(ST, d); check("R2 done cause bit7", d, 32'h080);
        reg_rd(XS, d); check("R8 done set", d, 32'h001);
        reg_rd(XS, d); check("R9 done read-cleared", d, 32'h000);
        pulse(7'h00, 5'h14);
        reg_rd(XS, d); check("R8 nack+timeout", d, 32'h014);
        reg_rd(XS, d); check("R9 others not read-cleared", d, 32'h014);
        reg_wr(XS, 32'h004);
        reg_rd(XS, d); check("R10 write clears nack", d, 32'h010);
        xfer_evt = 5'h01;
        reg_rd(XS, d);
        xfer_evt = '0;
        reg_rd(XS, d); check("R9 done event beats read clear", d, 32'h011);
        busy_slave = 1'b1;
        reg_rd(XS, d); check("R11 slave busy bit16", d, 32'h1_0010);
        busy_slave = 1'b0; busy_master = 1'b1;
        reg_rd(XS, d); check("R11 master busy bit17", d, 32'h2_0010);
        busy_master = 1'b0;
        clear_all();
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        reg_wr(EN, 32'h00F);
        pulse(7'h10, 5'h00);
        reg_wr(3, 32'hFFFF_FFFF);
        reg_wr(15, 32'hFFFF_FFFF);
        reg_rd(3, d);  check("R12 unmapped reads zero", d, 32'h0);
        reg_rd(EN, d); check("R12 enable untouched", d, 32'h00F);
        reg_rd(ST, d); check("R12 cause untouched", d, 32'h010);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_and_clear();
        t_same_cycle();
        t_enable_reg();
        t_irq();
        t_result();
        t_unmapped();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule